// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a hung two-wire bus back to its idle state before the master engine that shares the bus is allowed to run. A one-cycle `go` request starts a recovery pass. The pass clears the engine's sticky status flags and holds the engine in soft reset. It then looks at the synchronized clock and data lines. The bus counts as free only when both lines read high. If the bus is not free, the sequencer leaves SDA released and pulses SCL low and back high. A slave stuck in the middle of a byte can then clock out its remaining bits and let go of SDA.

The pulse loop is bounded by `MAX_TRY`. Each low phase lasts a number of system clocks taken from the `low_len` input, so the pulse width follows the clock frequency. When the pass ends, the soft reset is removed and `done` is raised for one cycle. `fail` is raised with `done` when the bus was still held after the last permitted pulse. Both lines are driven in open-drain fashion: an output enable of 1 pulls the line low, and 0 releases it.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `done`, `fail`, `eng_rst`, `scl_oe` and `sda_oe` are 0 and `flag_clr` is all zeros.
- R2: The cycle after `go` is taken in idle, `flag_clr` is all ones for exactly one cycle. Its bit order is [0] stop complete, [1] interrupt active, [2] arbitration lost, [3] incomplete transfer, [4] aborted transfer.
- R3: `eng_rst` is high from the flag-clear cycle through the last cycle of the pulse loop. It is low in the `done` cycle and while idle.
- R4: SCL and SDA pass through a two-stage synchronizer that resets to high. The bus is judged free only when both synchronized lines are 1. If the bus is free at the request, `done` rises in the third cycle after the `go` edge with `fail` low and no SCL pulse.
- R5: Each SCL pulse holds `scl_oe` high for `low_len` cycles. It then releases SCL for `low_len`+2 cycles before the bus is judged again. The two extra cycles cover the synchronizer delay.
- R6: At most `MAX_TRY` SCL pulses are issued per pass.
- R7: If the bus is free after the last permitted pulse, the pass ends with `fail` low. If it is still held, `fail` is asserted together with `done`.
- R8: `done` lasts exactly one cycle. A `go` that arrives while a pass is running, or in its `done` cycle, has no effect.
- R9: `sda_oe` is never asserted, so the sequencer cannot create a start or stop condition.
- R10: A `low_len` of 0 behaves exactly like a `low_len` of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle request to start a recovery pass |
| low_len | input | LEN_W | SCL low time in system clocks (0 treated as 1) |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 (held at 0) |
| eng_rst | output | 1 | Soft reset to the master engine |
| flag_clr | output | 5 | Write-1-to-clear strobes for the sticky status flags |
| done | output | 1 | One-cycle end-of-pass strobe |
| fail | output | 1 | With `done`: bus still held after the last pulse |

## Verification
The bench builds the block with `MAX_TRY` = 5 and `LEN_W` = 4. The small try limit lets a single run reach both sides of the limit: a slave that lets go on exactly the fifth pulse, and one that never does. The narrow length field keeps pulses to a few cycles, which allows `low_len` values of 0, 1, 3 and the field maximum of 15 to be tried. A bus model in the bench holds SDA low for a chosen number of SCL falls, or holds SCL low permanently. This covers the free-at-start case, recovery before the limit, recovery on the last pulse, and failure on either line.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } unstick_st_t;

  localparam int NUM_FLAGS = 5;
  localparam int SYNC_LAT  = 2;

  // Effective low-phase length: a zero request behaves as one cycle.
  function automatic int low_cycles(int unsigned req);
    return (req == 0) ? 1 : int'(req);
  endfunction

  // Released phase covers the low length plus the synchronizer latency.
  function automatic int high_cycles(int unsigned req);
    return low_cycles(req) + SYNC_LAT;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b1;
        st2 <= 1'b1;
      end else begin
        st1 <= raw[g];
        st2 <= st1;
      end
    end
    assign synced[g] = st2;
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] target,
  output logic          hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == target - 1'b1);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int MAX_TRY = 100,
  parameter int LEN_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [LEN_W-1:0]     low_len,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 scl_oe,
  output logic                 sda_oe,
  output logic                 eng_rst,
  output logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 done,
  output logic                 fail
);
  localparam int TW    = LEN_W + 2;
  localparam int TRY_W = $clog2(MAX_TRY + 1);

  unstick_st_t st, st_nx;
  logic [TRY_W-1:0] tries;
  logic             fail_r;
  logic [1:0]       lines_s;
  logic             free_s;
  logic             phase_hit;
  logic [TW-1:0]    low_tgt, high_tgt, tgt;
  logic             at_limit;

  i2c_line_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({scl_in, sda_in}),
    .synced(lines_s)
  );
  assign free_s = &lines_s;

  assign low_tgt  = TW'(low_cycles(int'(low_len)));
  assign high_tgt = TW'(high_cycles(int'(low_len)));
  assign tgt      = (st == ST_LOW) ? low_tgt : high_tgt;

  i2c_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .restart(st_nx != st),
    .target(tgt),
    .hit(phase_hit)
  );

  assign at_limit = (tries == TRY_W'(MAX_TRY));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (go) st_nx = ST_CLEAR;
      ST_CLEAR: st_nx = ST_CHECK;
      ST_CHECK: if (free_s || at_limit) st_nx = ST_DONE;
                else st_nx = ST_LOW;
      ST_LOW:   if (phase_hit) st_nx = ST_HIGH;
      ST_HIGH:  if (phase_hit) st_nx = ST_CHECK;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tries  <= '0;
      fail_r <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_CLEAR) tries <= '0;
      else if (st == ST_HIGH && phase_hit) tries <= tries + 1'b1;
      if (st == ST_CHECK) fail_r <= !free_s;
    end
  end

  assign scl_oe   = (st == ST_LOW);
  assign sda_oe   = 1'b0;
  assign eng_rst  = (st == ST_CLEAR) || (st == ST_CHECK) ||
                    (st == ST_LOW) || (st == ST_HIGH);
  assign flag_clr = {NUM_FLAGS{st == ST_CLEAR}};
  assign done     = (st == ST_DONE);
  assign fail     = (st == ST_DONE) && fail_r;

  // R3: SCL is only pulled while the engine is held in reset
  a_r3_pulse_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> eng_rst);

  // R2: flag strobe lasts one cycle and is followed by reset held
  a_r2_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != '0) |=> (flag_clr == '0) && eng_rst);

  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a passing end follows a free judgement
  a_r7_pass_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> $past(free_s));

  // R7: a failing end follows a held bus at the try limit
  a_r7_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!$past(free_s) && at_limit));

  // R6: pulse count never exceeds the limit
  a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRY));

endmodule

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;
  localparam int MAXT = 5;
  localparam int LW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [LW-1:0] low_len = '0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_oe, sda_oe, eng_rst, done, fail;
  logic [4:0] flag_clr;

  always #2 clk = ~clk;

  i2c_bus_unstick #(.MAX_TRY(MAXT), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .low_len(low_len),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .eng_rst(eng_rst), .flag_clr(flag_clr), .done(done), .fail(fail)
  );

  int vecs = 0, bad = 0, cyc = 0;

  // bus model configuration
  int sda_hold = 0;   // SDA held until this many SCL falls
  bit scl_jam = 0;
  int falls = 0;
  bit prev_oe = 0;

  // reference model
  int m = 0, mt = 0, mtries = 0;
  bit mfail = 0;
  bit q0 = 1, q1 = 1;

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m = 0; mt = 0; mtries = 0; mfail = 0; q0 = 1; q1 = 1;
    end else begin
      bit dec;
      int ln;
      ln = (low_len == 0) ? 1 : int'(low_len);
      dec = q1; q1 = q0; q0 = scl_in & sda_in;
      case (m)
        0: if (go) m = 1;
        1: begin m = 2; mtries = 0; end
        2: if (dec) begin m = 5; mfail = 0; end
           else if (mtries == MAXT) begin m = 5; mfail = 1; end
           else begin m = 3; mt = 0; end
        3: begin mt++; if (mt == ln) begin m = 4; mt = 0; end end
        4: begin mt++; if (mt == ln + 2) begin m = 2; mtries++; end end
        default: m = 0;
      endcase
    end
  end

  // compare every cycle, then update the bus model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(done == (m == 5), "R8 done", done, m == 5);
      chk(fail == (m == 5 && mfail), "R7 fail", fail, m == 5 && mfail);
      chk(eng_rst == (m >= 1 && m <= 4), "R3 eng_rst", eng_rst, m >= 1 && m <= 4);
      chk(scl_oe == (m == 3), "R5 scl_oe", scl_oe, m == 3);
      chk(flag_clr == ((m == 1) ? 5'h1f : 5'h00), "R2 flag_clr", flag_clr,
          (m == 1) ? 31 : 0);
      chk(sda_oe == 1'b0, "R9 sda_oe", sda_oe, 0);
    end
    if (scl_oe && !prev_oe) falls++;
    prev_oe = scl_oe;
    scl_in = !scl_oe && !scl_jam;
    sda_in = (falls >= sda_hold);
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic pass(int hold, bit jam, int len, bit extra_go,
                      output int pulses, output bit f);
    int base, n;
    sda_hold = hold + falls; scl_jam = jam; low_len = LW'(len);
    repeat (3) @(negedge clk);
    base = falls;
    go = 1'b1; @(negedge clk); go = 1'b0;
    n = 0; f = 0;
    while (!done && n < 2000) begin
      if (extra_go && n == 4) go = 1'b1;
      @(negedge clk); #0;
      go = 1'b0;
      n++;
    end
    f = fail;
    if (extra_go) begin go = 1'b1; @(negedge clk); go = 1'b0; end
    pulses = falls - base;
    scl_jam = 0; sda_hold = falls;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int p; bit f;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!done && !fail && !eng_rst && !scl_oe && !sda_oe && flag_clr == 0,
        "R1 reset", {done, fail, eng_rst, scl_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4: free bus, no pulse
    pass(0, 0, 3, 0, p, f);
    chk(p == 0, "R4 pulses", p, 0);
    chk(f == 0, "R4 fail", f, 0);
    // R5: stuck SDA released after 2 pulses
    pass(2, 0, 3, 0, p, f);
    chk(p == 2, "R5 pulses", p, 2);
    chk(f == 0, "R5 fail", f, 0);
    // R7: released on the last permitted pulse
    pass(MAXT, 0, 1, 0, p, f);
    chk(p == MAXT, "R7 pulses", p, MAXT);
    chk(f == 0, "R7 pass at limit", f, 0);
    // R6: never released
    pass(9, 0, 2, 0, p, f);
    chk(p == MAXT, "R6 pulses", p, MAXT);
    chk(f == 1, "R6 fail", f, 1);
    // R6: SCL jammed low
    pass(0, 1, 3, 0, p, f);
    chk(p == MAXT, "R6 jam pulses", p, MAXT);
    chk(f == 1, "R6 jam fail", f, 1);
    // R10: zero length acts as one
    pass(3, 0, 0, 0, p, f);
    chk(p == 3, "R10 pulses", p, 3);
    chk(f == 0, "R10 fail", f, 0);
    // R8: go while busy and during done is ignored
    pass(2, 0, 2, 1, p, f);
    chk(p == 2, "R8 pulses", p, 2);
    chk(!eng_rst && !scl_oe, "R8 idle after", {eng_rst, scl_oe}, 0);
    // R5: widest length field
    pass(1, 0, 15, 0, p, f);
    chk(p == 1, "R5 long pulse", p, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule